// File: doc/BRIEF.md
# Dual-Slope Symmetric PWM Timer

This block is an 8-bit up/down timer that produces a centre-aligned PWM waveform on one output. On every enabled timer tick the count moves one step. It climbs from zero to a ceiling, stays at the ceiling for a single tick, and then falls back to zero. At zero it turns and climbs again. The ceiling is either the full-scale value 255 or a value supplied on an input. A 2-bit output mode decides whether the pin follows the waveform, follows its complement, or stays low. A sticky flag marks each return to zero, and a clear pulse resets it.

Software writes the compare threshold into a holding register. The threshold the comparator uses is reloaded from that register only at the turnaround at the ceiling, so a period never starts with one threshold and ends with another. The tick enable comes from an external prescaler that divides the clock by 1, 8, 32, 64, 128, 256 or 1024. One PWM period is twice the ceiling in ticks. With the full-scale ceiling the pin frequency is therefore the clock frequency divided by 510 times the division factor.

Top module: `pwm_timer`

## Requirements
- R1: On each cycle with tick_i high, count_o moves one step in its current direction. It rises from 0 to the ceiling, falls from the ceiling to 0, and repeats.
- R2: With top_sel_i = 0 the ceiling is 255. With top_sel_i = 1 the ceiling is top_val_i.
- R3: The count stays at the ceiling for exactly one tick, so the value after the ceiling is the ceiling minus one.
- R4: On a cycle with tick_i low, count_o, pwm_o and bot_flag_o do not change.
- R5: bot_flag_o goes high on the tick on which the falling count reaches 0. It stays high until a cycle with bot_clr_i high.
- R6: A cycle with cmp_wr_i high stores cmp_val_i in a holding register. The active threshold takes the held value only on the tick that turns the count down from the ceiling. Until that tick the waveform follows the old threshold (0 after reset).
- R7: With out_mode_i = 2 (true polarity), a rising count that reaches the threshold drives pwm_o low, and a falling count that reaches the threshold drives it high. After a rising tick the level is high exactly when count < threshold. After a falling tick it is high exactly when count <= threshold.
- R8: With out_mode_i = 3, pwm_o is the complement of the mode-2 level. With out_mode_i = 0 or 1, pwm_o is held low.
- R9: In mode 2, an active threshold of 0 keeps pwm_o low for the whole period, and an active threshold of 255 keeps it high for the whole period.
- R10: When the active threshold moves away from 255, pwm_o takes the level that a rising-count match would have produced (low in mode 2). It then goes high again only at the falling match.
- R11: If the count starts falling from a value above a newly loaded threshold, so that the rising match never took place, pwm_o still makes the rising-match transition (low in mode 2) on the turnaround tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timer step enable from the prescaler |
| top_sel_i | input | 1 | Ceiling select: 0 = 255, 1 = top_val_i |
| top_val_i | input | 8 | Programmable ceiling |
| out_mode_i | input | 2 | Output mode: 0/1 off, 2 true, 3 inverted |
| cmp_wr_i | input | 1 | Write strobe for the threshold holding register |
| cmp_val_i | input | 8 | Threshold write data |
| bot_clr_i | input | 1 | Clears the bottom flag |
| pwm_o | output | 1 | PWM output pin value |
| count_o | output | 8 | Live count |
| bot_flag_o | output | 1 | Sticky flag for arrival at zero |

## Verification
The bench places the turnaround exactly. A counter that left the ceiling after zero ticks or after two would put every later sample and the bottom flag one tick early or late. It loads a new threshold just before the ceiling and checks that nothing changes before the turnaround, which catches a design whose writes take effect at once and glitch the current period. It covers both extreme thresholds over a whole period; a plain level comparison would give a one-tick spike at zero or a dip at 255. It also covers two correction cases, a threshold leaving 255 and a threshold loaded below the count at the ceiling. A design without the correction would keep the pin high through the first half of the falling ramp.

// File: rtl/ppwm_pkg.sv
package ppwm_pkg;

    // Default width of the count and the compare threshold.
    localparam int CNT_W = 8;

    // Output mode codes: only 2 and 3 drive the pin.
    typedef enum logic [1:0] {
        OM_OFF_A = 2'd0,
        OM_OFF_B = 2'd1,
        OM_TRUE  = 2'd2,
        OM_INV   = 2'd3
    } out_mode_e;

    typedef struct packed {
        logic flag;
    } bflag_t;

endpackage

// File: rtl/dslope_counter.sv
// Up/down counter that turns at the ceiling and at zero.
module dslope_counter #(
    parameter int W = ppwm_pkg::CNT_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic [W-1:0] top_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] nxt_cnt_o,
    output logic         nxt_up_o,
    output logic         turn_o,
    output logic         bottom_o
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         up;
    } cstate_t;

    cstate_t st_d, st_q;
    logic    turn_d, bottom_d;

    always_comb begin
        st_d     = st_q;
        turn_d   = 1'b0;
        bottom_d = 1'b0;
        if (tick_i) begin
            if (st_q.up) begin
                if (st_q.cnt >= top_i) begin
                    if (st_q.cnt == ZERO) begin
                        // Zero ceiling: park at zero.
                        st_d.cnt = ZERO;
                    end else begin
                        // Ceiling was held for one tick; begin the descent.
                        st_d.cnt = st_q.cnt - ONE;
                        st_d.up  = 1'b0;
                        turn_d   = 1'b1;
                        bottom_d = (st_q.cnt == ONE);
                    end
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else begin
                if (st_q.cnt == ZERO) begin
                    st_d.up  = 1'b1;
                    st_d.cnt = (top_i == ZERO) ? ZERO : ONE;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                    bottom_d = (st_q.cnt == ONE);
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{cnt: ZERO, up: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign nxt_cnt_o = st_d.cnt;
    assign nxt_up_o  = st_d.up;
    assign turn_o    = turn_d;
    assign bottom_o  = bottom_d;

endmodule

// File: rtl/cmp_buffer.sv
// Holding register plus active threshold, reloaded at the turnaround.
module cmp_buffer #(
    parameter int W = ppwm_pkg::CNT_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         load_i,
    output logic [W-1:0] act_o,
    output logic [W-1:0] eff_o
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic [W-1:0] act;
    } bstate_t;

    bstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.hold = wdata_i;
        end
        if (load_i) begin
            // The value held before this cycle's write is promoted.
            st_d.act = st_q.hold;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o = st_q.act;
    // Threshold that governs the tick in progress.
    assign eff_o = load_i ? st_q.hold : st_q.act;

endmodule

// File: rtl/wave_gen.sv
// Waveform level register and output polarity selection.
module wave_gen #(
    parameter int W = ppwm_pkg::CNT_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic [W-1:0] nxt_cnt_i,
    input  logic         nxt_up_i,
    input  logic [W-1:0] thr_i,
    input  logic [1:0]   mode_i,
    output logic         pwm_o
);
    import ppwm_pkg::*;

    localparam logic [W-1:0] MIN_V = '0;
    localparam logic [W-1:0] MAX_V = '1;

    typedef struct packed {
        logic lvl;
    } wstate_t;

    wstate_t   st_d, st_q;
    out_mode_e mode;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (thr_i == MIN_V) begin
                st_d.lvl = 1'b0;
            end else if (thr_i == MAX_V) begin
                st_d.lvl = 1'b1;
            end else if (nxt_up_i) begin
                // Rising: cleared from the match upward.
                st_d.lvl = (nxt_cnt_i < thr_i);
            end else begin
                // Falling: set from the match downward. A turnaround from
                // above the threshold yields low, which supplies any missed
                // rising-match transition.
                st_d.lvl = (nxt_cnt_i <= thr_i);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = out_mode_e'(mode_i);

    always_comb begin
        unique case (mode)
            OM_TRUE: pwm_o = st_q.lvl;
            OM_INV:  pwm_o = ~st_q.lvl;
            default: pwm_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
    parameter int W = ppwm_pkg::CNT_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         top_sel_i,
    input  logic [W-1:0] top_val_i,
    input  logic [1:0]   out_mode_i,
    input  logic         cmp_wr_i,
    input  logic [W-1:0] cmp_val_i,
    input  logic         bot_clr_i,
    output logic         pwm_o,
    output logic [W-1:0] count_o,
    output logic         bot_flag_o
);
    import ppwm_pkg::*;

    localparam logic [W-1:0] FULL = '1;

    logic [W-1:0] top_eff;
    logic [W-1:0] nxt_cnt;
    logic         nxt_up;
    logic         turn;
    logic         bottom;
    logic [W-1:0] cmp_act;
    logic [W-1:0] cmp_eff;

    bflag_t fl_d, fl_q;

    assign top_eff = top_sel_i ? top_val_i : FULL;

    dslope_counter #(.W(W)) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .top_i    (top_eff),
        .cnt_o    (count_o),
        .nxt_cnt_o(nxt_cnt),
        .nxt_up_o (nxt_up),
        .turn_o   (turn),
        .bottom_o (bottom)
    );

    cmp_buffer #(.W(W)) u_cmp (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (cmp_wr_i),
        .wdata_i(cmp_val_i),
        .load_i (turn),
        .act_o  (cmp_act),
        .eff_o  (cmp_eff)
    );

    wave_gen #(.W(W)) u_wave (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .nxt_cnt_i(nxt_cnt),
        .nxt_up_i (nxt_up),
        .thr_i    (cmp_eff),
        .mode_i   (out_mode_i),
        .pwm_o    (pwm_o)
    );

    // Sticky bottom flag; an arrival in the same cycle as a clear wins.
    always_comb begin
        fl_d = fl_q;
        if (bot_clr_i) begin
            fl_d.flag = 1'b0;
        end
        if (bottom) begin
            fl_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign bot_flag_o = fl_q.flag;

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
    parameter int W = 8
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         tick_i,
    input logic         bot_clr_i,
    input logic [1:0]   out_mode_i,
    input logic [W-1:0] count_o,
    input logic         bot_flag_o,
    input logic         pwm_o,
    input logic [W-1:0] cmp_act
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] FULL = '1;

    // R1: one step per tick, or parked at zero
    a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> (count_o == $past(count_o) + ONE) ||
                   (count_o == $past(count_o) - ONE) ||
                   (count_o == ZERO && $past(count_o) == ZERO));

    // R4: idle cycles change nothing
    a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(count_o) && $stable(bot_flag_o) && $stable(cmp_act));

    // R5: flag is sticky without a clear
    a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bot_flag_o && !bot_clr_i) |=> bot_flag_o);

    // R5: arrival at zero from one sets the flag
    a_r5_bottom_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && count_o == ONE) |=> (count_o != ZERO) || bot_flag_o);

    // R8: off modes drive low
    a_r8_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_mode_i[1] == 1'b0) |-> !pwm_o);

    // R9: threshold zero keeps the true-polarity output low
    a_r9_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_mode_i == 2'd2 && cmp_act == ZERO) |-> !pwm_o);

    // R9: full-scale threshold keeps the true-polarity output high
    a_r9_max_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_mode_i == 2'd2 && cmp_act == FULL) |-> pwm_o);

endmodule

bind pwm_timer pwm_timer_chk #(.W(W)) u_pwm_timer_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .bot_clr_i (bot_clr_i),
    .out_mode_i(out_mode_i),
    .count_o   (count_o),
    .bot_flag_o(bot_flag_o),
    .pwm_o     (pwm_o),
    .cmp_act   (cmp_act)
);

// File: tb/pwm_timer_bench.sv
module pwm_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic       top_sel;
    logic [7:0] top_val;
    logic [1:0] mode;
    logic       cmp_wr;
    logic [7:0] cmp_val;
    logic       bot_clr;
    logic       pwm;
    logic [7:0] count;
    logic       flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_timer u_pwm_timer (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .top_sel_i (top_sel),
        .top_val_i (top_val),
        .out_mode_i(mode),
        .cmp_wr_i  (cmp_wr),
        .cmp_val_i (cmp_val),
        .bot_clr_i (bot_clr),
        .pwm_o     (pwm),
        .count_o   (count),
        .bot_flag_o(flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Inputs change 1 time unit after a rising edge; samples are taken there too.
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset(input bit sel, input logic [7:0] tv, input logic [1:0] m);
        rst_n   = 1'b0;
        tick    = 1'b1;
        top_sel = sel;
        top_val = tv;
        mode    = m;
        cmp_wr  = 1'b0;
        cmp_val = 8'd0;
        bot_clr = 1'b0;
        run(2);
        rst_n = 1'b1;
    endtask

    // Write the holding register on a cycle without a tick.
    task automatic write_cmp(input logic [7:0] v);
        tick    = 1'b0;
        cmp_wr  = 1'b1;
        cmp_val = v;
        run(1);
        cmp_wr = 1'b0;
        tick   = 1'b1;
    endtask

    task automatic t_reset;
        do_reset(1'b0, 8'd0, 2'd2);
        chk("R1 reset count", count, 0);
        chk("R5 reset flag", flag, 0);
        chk("R9 reset pwm", pwm, 0);
    endtask

    task automatic t_fixed_top;
        do_reset(1'b0, 8'd0, 2'd2);
        run(255);
        chk("R2 fixed ceiling reached", count, 255);
        run(1);
        chk("R3 one tick at ceiling", count, 254);
        run(253);
        chk("R1 falling to one", count, 1);
        chk("R5 flag before zero", flag, 0);
        run(1);
        chk("R1 reaches zero", count, 0);
        chk("R5 flag at zero", flag, 1);
        run(1);
        chk("R1 rises again", count, 1);
    endtask

    task automatic t_prog_top;
        do_reset(1'b1, 8'd10, 2'd2);
        run(10);
        chk("R2 programmable ceiling", count, 10);
        run(1);
        chk("R3 ceiling held one tick", count, 9);
        run(9);
        chk("R1 back at zero", count, 0);
        chk("R5 flag set", flag, 1);
    endtask

    task automatic t_flag_clear;
        do_reset(1'b1, 8'd10, 2'd2);
        run(20);
        bot_clr = 1'b1;
        run(1);
        bot_clr = 1'b0;
        chk("R5 cleared", flag, 0);
        run(5);
        chk("R5 stays clear", flag, 0);
        run(14);
        chk("R5 set at next zero", flag, 1);
        run(3);
        chk("R5 sticky", flag, 1);
    endtask

    task automatic t_tick_gate;
        do_reset(1'b1, 8'd10, 2'd2);
        write_cmp(8'd4);
        run(3);
        chk("R4 three ticks", count, 3);
        tick = 1'b0;
        run(5);
        chk("R4 count holds", count, 3);
        chk("R4 flag holds", flag, 0);
        chk("R4 pwm holds", pwm, 0);
        tick = 1'b1;
        run(1);
        chk("R4 resumes", count, 4);
    endtask

    task automatic t_buffered;
        do_reset(1'b1, 8'd10, 2'd2);
        write_cmp(8'd4);
        run(2);
        chk("R6 old threshold still active", pwm, 0);
        run(13);
        chk("R7 count 5 falling", count, 5);
        chk("R7 above threshold falling", pwm, 0);
        run(1);
        chk("R7 falling match sets", pwm, 1);
        run(7);
        chk("R7 count 3 rising", count, 3);
        chk("R7 below threshold rising", pwm, 1);
        run(1);
        chk("R7 rising match clears", pwm, 0);
    endtask

    task automatic t_modes;
        do_reset(1'b1, 8'd10, 2'd3);
        write_cmp(8'd4);
        run(15);
        chk("R8 inverted above threshold", pwm, 1);
        run(1);
        chk("R8 inverted after falling match", pwm, 0);
        mode = 2'd0;
        #1;
        chk("R8 mode 0 low", pwm, 0);
        mode = 2'd1;
        #1;
        chk("R8 mode 1 low", pwm, 0);
        mode = 2'd2;
        #1;
        chk("R8 mode 2 same level", pwm, 1);
    endtask

    task automatic t_extreme_zero;
        int bad = 0;
        do_reset(1'b1, 8'd10, 2'd2);
        for (int i = 0; i < 40; i++) begin
            run(1);
            if (pwm != 1'b0) bad++;
        end
        chk("R9 threshold 0 never high (bad ticks)", bad, 0);
    endtask

    task automatic t_extreme_max;
        int bad = 0;
        do_reset(1'b0, 8'd0, 2'd2);
        write_cmp(8'd255);
        run(255);
        for (int i = 0; i < 510; i++) begin
            run(1);
            if (pwm != 1'b1) bad++;
        end
        chk("R9 threshold 255 never low (bad ticks)", bad, 0);
    endtask

    task automatic t_leave_max;
        do_reset(1'b0, 8'd0, 2'd2);
        write_cmp(8'd255);
        run(765);
        chk("R10 high at ceiling with 255", pwm, 1);
        write_cmp(8'd100);
        run(1);
        chk("R10 turnaround count", count, 254);
        chk("R10 forced to rising-match level", pwm, 0);
        run(153);
        chk("R10 still low above threshold", pwm, 0);
        run(1);
        chk("R10 high at falling match", pwm, 1);
    endtask

    task automatic t_missed_match;
        do_reset(1'b1, 8'd10, 2'd2);
        write_cmp(8'd20);
        run(11);
        write_cmp(8'd5);
        run(19);
        chk("R11 count at ceiling", count, 10);
        chk("R11 high with threshold above ceiling", pwm, 1);
        run(1);
        chk("R11 missed match corrected", pwm, 0);
        run(4);
        chk("R11 falling match sets", pwm, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fixed_top();
        t_prog_top();
        t_flag_clear();
        t_tick_gate();
        t_buffered();
        t_modes();
        t_extreme_zero();
        t_extreme_max();
        t_leave_max();
        t_missed_match();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule